// File: doc/BRIEF.md
# Low-Frequency Register Write Synchronizer

This block carries software writes from a fast bus clock into a slow counter clock. It has four write targets, selected by a two-bit code: control (0), command (1), top buffer (2) and oversampling configuration (3). Each target has its own busy flag. A write is captured in the bus domain and sent across with a toggle request and a toggle acknowledge. Each direction passes through a two-flop synchronizer. The busy flag for a target stays high until the acknowledge for that target has come back.

A freeze input lets software stage a group of writes. While freeze is high, writes are held in the bus domain and each new write overwrites any earlier held value for the same target. When freeze drops, every held write is sent across together.

Command writes do not leave a stored value in the slow domain. Each one becomes a single-cycle pulse on one or both command outputs. One bit of the control word is a counter-reset enable, and it goes straight to the counter datapath without waiting for the handshake.

Top module: `lf_write_sync`

## Requirements
- R1: After reset the following outputs are zero: `busy`, `wr_err`, `cnt_clear`, `lf_ctrl`, `lf_topb`, `lf_ovscfg`, `lf_load_top` and `lf_load_cnt`.
- R2: An accepted write raises `busy[wr_sel]` by the next bus-clock edge. That bit clears only after the value is present on the slow-domain outputs.
- R3: With freeze low, an accepted write to control (0), top buffer (2) or oversampling configuration (3) sets `lf_ctrl`, `lf_topb` or `lf_ovscfg` to the written data. The value appears no earlier than the third and no later than the fourth rising `lf_clk` edge after the bus edge that took the write.
- R4: Command writes (select 1) are turned into one-`lf_clk`-cycle pulses. Data bit 0 pulses `lf_load_top` and data bit 1 pulses `lf_load_cnt`. Each command write gives exactly one pulse per set bit.
- R5: A write with freeze low to a target whose busy bit is set is dropped, and the slow-domain value for that target is left unchanged. Such a write sets the sticky `wr_err`, which only a bus reset clears.
- R6: While `freeze` is high, writes are accepted whatever the busy state and without raising `wr_err`. Held writes never reach the slow outputs and produce no command pulse.
- R7: When `freeze` falls, every target with a held write commits it. Only the last value written to each target is committed, so a held command produces only the pulses for its last value.
- R8: Bit RSTEN_BIT (default 7) of an accepted control write sets `cnt_clear` at the next bus-clock edge, with freeze high or low. The same control write still raises `busy[0]` and is synchronized normally.
- R9: The two domains use independent asynchronous active-low resets. The bus side comes out of reset with `busy` at zero even while `lf_rst_n` is still held low.
- R10: Busy targets do not block each other. A write to an idle target is accepted while another target is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_sel | input | 2 | Target: 0 control, 1 command, 2 top buffer, 3 oversampling config |
| wr_data | input | DW | Write data |
| freeze | input | 1 | Hold writes in the bus domain while high |
| busy | output | 4 | Per-target busy flags, indexed by select code |
| wr_err | output | 1 | Sticky flag for a write dropped because its target was busy |
| cnt_clear | output | 1 | Counter-reset enable, set directly by control writes |
| lf_clk | input | 1 | Slow counter clock |
| lf_rst_n | input | 1 | Slow-domain asynchronous reset, active low |
| lf_ctrl | output | DW | Committed control value |
| lf_topb | output | DW | Committed top-buffer value |
| lf_ovscfg | output | DW | Committed oversampling configuration |
| lf_load_top | output | 1 | One-cycle pulse: load top from buffer |
| lf_load_cnt | output | 1 | One-cycle pulse: load counter from top |

## Verification
Assertions check the following on every cycle:
- a taken write raises its busy flag;
- a busy-collision write sets the error flag, and the flag stays set;
- freeze stops every request toggle;
- the reset-enable output follows the control write at once;
- each command pulse lasts one slow cycle.

Some behaviour can only be shown by the bench scenarios:
- the three-to-four slow-edge latency;
- that a held write replaces an earlier held write;
- that releasing freeze commits everything together, with only the final command pulses;
- that the bus side leaves reset cleanly while the slow side is still held in reset.

// File: rtl/lf_write_sync.sv
module lf_write_sync #(
  parameter int DW        = 16,
  parameter int RSTEN_BIT = 7
) (
  input  logic          bus_clk,
  input  logic          bus_rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          freeze,
  output logic [3:0]    busy,
  output logic          wr_err,
  output logic          cnt_clear,
  input  logic          lf_clk,
  input  logic          lf_rst_n,
  output logic [DW-1:0] lf_ctrl,
  output logic [DW-1:0] lf_topb,
  output logic [DW-1:0] lf_ovscfg,
  output logic          lf_load_top,
  output logic          lf_load_cnt
);
  localparam int NT = 4;

  logic [NT-1:0][DW-1:0] hold_q, xfer_q;
  logic [NT-1:0] pend_q, req_q, ack_m, ack_s;
  logic [NT-1:0] rs1, rs2, rs3;

  wire [NT-1:0] inflight = req_q ^ ack_s;
  assign busy = pend_q | inflight;

  wire [NT-1:0] sel_oh = wr_en ? (NT'(1) << wr_sel) : '0;
  wire          reject = wr_en && !freeze && busy[wr_sel];
  wire [NT-1:0] accept = reject ? '0 : sel_oh;
  wire [NT-1:0] launch = pend_q & ~inflight & {NT{~freeze}};

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      hold_q    <= '0;
      xfer_q    <= '0;
      pend_q    <= '0;
      req_q     <= '0;
      ack_m     <= '0;
      ack_s     <= '0;
      wr_err    <= 1'b0;
      cnt_clear <= 1'b0;
    end else begin
      ack_m <= rs3;
      ack_s <= ack_m;
      for (int i = 0; i < NT; i++) begin
        if (accept[i]) begin
          hold_q[i] <= wr_data;
          pend_q[i] <= 1'b1;
        end else if (launch[i]) begin
          pend_q[i] <= 1'b0;
          xfer_q[i] <= hold_q[i];
          req_q[i]  <= ~req_q[i];
        end
      end
      if (reject) wr_err <= 1'b1;
      if (accept[0]) cnt_clear <= wr_data[RSTEN_BIT];
    end
  end

  wire [NT-1:0] arrive = rs2 ^ rs3;

  always_ff @(posedge lf_clk or negedge lf_rst_n) begin
    if (!lf_rst_n) begin
      rs1         <= '0;
      rs2         <= '0;
      rs3         <= '0;
      lf_ctrl     <= '0;
      lf_topb     <= '0;
      lf_ovscfg   <= '0;
      lf_load_top <= 1'b0;
      lf_load_cnt <= 1'b0;
    end else begin
      rs1 <= req_q;
      rs2 <= rs1;
      rs3 <= rs2;
      if (arrive[0]) lf_ctrl   <= xfer_q[0];
      if (arrive[2]) lf_topb   <= xfer_q[2];
      if (arrive[3]) lf_ovscfg <= xfer_q[3];
      lf_load_top <= arrive[1] & xfer_q[1][0];
      lf_load_cnt <= arrive[1] & xfer_q[1][1];
    end
  end

  for (genvar g = 0; g < NT; g++) begin : g_chk
    p_busy_set_r2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (wr_en && wr_sel == g && (freeze || !busy[g])) |=> busy[g]);
    p_freeze_holds_r6: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      freeze |=> $stable(req_q[g]));
  end

  p_reject_err_r5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (wr_en && !freeze && busy[wr_sel]) |=> wr_err);
  p_err_sticky_r5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    wr_err |=> wr_err);
  p_rsten_direct_r8: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (wr_en && wr_sel == 2'd0 && (freeze || !busy[0])) |=> cnt_clear == $past(wr_data[RSTEN_BIT]));
  p_top_pulse_r4: assert property (@(posedge lf_clk) disable iff (!lf_rst_n)
    lf_load_top |=> !lf_load_top);
  p_cnt_pulse_r4: assert property (@(posedge lf_clk) disable iff (!lf_rst_n)
    lf_load_cnt |=> !lf_load_cnt);
endmodule

// File: tb/sim_lf_write_sync.sv
`timescale 1ns/1ps
module sim_lf_write_sync;
  localparam int DW = 16;

  logic bus_clk = 0, lf_clk = 0;
  logic bus_rst_n = 0, lf_rst_n = 0;
  logic wr_en = 0, freeze = 0;
  logic [1:0] wr_sel = 0;
  logic [DW-1:0] wr_data = 0;
  logic [3:0] busy;
  logic wr_err, cnt_clear, lf_load_top, lf_load_cnt;
  logic [DW-1:0] lf_ctrl, lf_topb, lf_ovscfg;

  always #2.5 bus_clk = ~bus_clk;
  initial begin #7; forever #20 lf_clk = ~lf_clk; end

  lf_write_sync #(.DW(DW), .RSTEN_BIT(7)) u0 (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .freeze(freeze), .busy(busy), .wr_err(wr_err),
    .cnt_clear(cnt_clear), .lf_clk(lf_clk), .lf_rst_n(lf_rst_n),
    .lf_ctrl(lf_ctrl), .lf_topb(lf_topb), .lf_ovscfg(lf_ovscfg),
    .lf_load_top(lf_load_top), .lf_load_cnt(lf_load_cnt));

  int checks = 0, errors = 0;
  int lf_edges = 0, n_top = 0, n_cnt = 0;
  logic [DW-1:0] m_val [4];
  logic m_err = 0, m_clr = 0;
  bit compare_on = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge lf_clk) lf_edges++;
  always @(negedge lf_clk) begin
    if (lf_load_top) n_top++;
    if (lf_load_cnt) n_cnt++;
  end

  always @(negedge bus_clk) if (compare_on) begin
    chk(wr_err == m_err, "R5 err", wr_err, m_err);
    chk(cnt_clear == m_clr, "R8 clear", cnt_clear, m_clr);
    if (!busy[0]) chk(lf_ctrl == m_val[0], "R2 ctrl idle", lf_ctrl, m_val[0]);
    if (!busy[2]) chk(lf_topb == m_val[2], "R2 topb idle", lf_topb, m_val[2]);
    if (!busy[3]) chk(lf_ovscfg == m_val[3], "R2 ovs idle", lf_ovscfg, m_val[3]);
  end

  task automatic wr(input logic [1:0] s, input logic [DW-1:0] d);
    bit acc;
    @(negedge bus_clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    acc = freeze || !busy[s];
    @(posedge bus_clk);
    if (acc) begin
      m_val[s] = d;
      if (s == 0) m_clr = d[7];
    end else m_err = 1;
    @(negedge bus_clk);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy != 0 && n < 400) begin @(negedge bus_clk); n++; end
    chk(busy == 0, "R2 busy clears", busy, 0);
    repeat (2) @(negedge lf_clk);
    @(negedge bus_clk);
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #500000;
    chk(0, "watchdog", 0, 1);
    finish_sim();
  end

  initial begin
    int e0, t0, c0;
    for (int i = 0; i < 4; i++) m_val[i] = '0;
    repeat (3) @(negedge bus_clk);
    bus_rst_n = 1;
    repeat (4) @(negedge bus_clk);
    // R1 / R9: bus side out of reset, slow side still in reset
    chk(busy == 0, "R9 busy while lf reset", busy, 0);
    chk(wr_err == 0, "R1 err", wr_err, 0);
    chk(cnt_clear == 0, "R1 clear", cnt_clear, 0);
    chk(lf_ctrl == 0 && lf_topb == 0 && lf_ovscfg == 0, "R1 lf regs", lf_ctrl, 0);
    chk(!lf_load_top && !lf_load_cnt, "R1 pulses", {lf_load_top, lf_load_cnt}, 0);
    @(negedge lf_clk); lf_rst_n = 1;
    repeat (2) @(negedge lf_clk);
    @(negedge bus_clk);
    compare_on = 1;

    // R2 / R3: single control write and its latency
    e0 = lf_edges;
    wr(2'd0, 16'h1234);
    chk(busy[0] == 1, "R2 busy set", busy, 4'h1);
    begin
      int n = 0;
      while (lf_ctrl != 16'h1234 && n < 400) begin @(negedge bus_clk); n++; end
    end
    chk(lf_edges - e0 >= 3 && lf_edges - e0 <= 4, "R3 latency", lf_edges - e0, 4);
    wait_idle();
    chk(lf_ctrl == 16'h1234, "R3 ctrl value", lf_ctrl, 16'h1234);

    // R10: different targets back to back
    wr(2'd2, 16'h00A5);
    wr(2'd3, 16'h0F0F);
    chk(busy[2] && busy[3], "R10 both busy", busy, 4'hC);
    chk(wr_err == 0, "R10 no err", wr_err, 0);
    wait_idle();
    chk(lf_topb == 16'h00A5 && lf_ovscfg == 16'h0F0F, "R10 values", lf_topb, 16'h00A5);

    // R5: rewrite while busy is dropped
    wr(2'd2, 16'h0011);
    wr(2'd2, 16'h0022);
    chk(wr_err == 1, "R5 err set", wr_err, 1);
    wait_idle();
    chk(lf_topb == 16'h0011, "R5 dropped write", lf_topb, 16'h0011);

    // R4: command pulses
    t0 = n_top; c0 = n_cnt;
    wr(2'd1, 16'h0001); wait_idle();
    chk(n_top - t0 == 1 && n_cnt - c0 == 0, "R4 cmd top", n_top - t0, 1);
    wr(2'd1, 16'h0002); wait_idle();
    chk(n_top - t0 == 1 && n_cnt - c0 == 1, "R4 cmd cnt", n_cnt - c0, 1);
    wr(2'd1, 16'h0003); wait_idle();
    chk(n_top - t0 == 2 && n_cnt - c0 == 2, "R4 cmd both", n_top - t0, 2);

    // R8: reset-enable acts before synchronization
    wr(2'd0, 16'h0080);
    chk(cnt_clear == 1, "R8 immediate", cnt_clear, 1);
    chk(busy[0] == 1 && lf_ctrl == 16'h1234, "R8 ctrl busy, slow old", lf_ctrl, 16'h1234);
    wait_idle();
    chk(lf_ctrl == 16'h0080, "R8 ctrl synced", lf_ctrl, 16'h0080);
    wr(2'd0, 16'h0000); wait_idle();
    chk(cnt_clear == 0, "R8 cleared", cnt_clear, 0);

    // R6 / R7: freeze batch
    @(negedge bus_clk); freeze = 1;
    t0 = n_top; c0 = n_cnt;
    wr(2'd0, 16'h0081);
    wr(2'd0, 16'h0102);
    wr(2'd2, 16'h0033);
    wr(2'd1, 16'h0001);
    wr(2'd1, 16'h0002);
    chk(cnt_clear == 0, "R8 clear under freeze", cnt_clear, 0);
    repeat (20) @(negedge lf_clk);
    @(negedge bus_clk);
    chk(lf_ctrl == 16'h0000, "R6 ctrl held", lf_ctrl, 0);
    chk(lf_topb == 16'h0011, "R6 topb held", lf_topb, 16'h0011);
    chk(n_top == t0 && n_cnt == c0, "R6 no pulse", n_top - t0, 0);
    chk(busy[0] && busy[1] && busy[2], "R6 held busy", busy, 4'h7);
    freeze = 0;
    wait_idle();
    chk(lf_ctrl == 16'h0102, "R7 ctrl last", lf_ctrl, 16'h0102);
    chk(lf_topb == 16'h0033, "R7 topb", lf_topb, 16'h0033);
    chk(n_top - t0 == 0 && n_cnt - c0 == 1, "R7 last cmd only", n_cnt - c0, 1);
    chk(lf_ovscfg == 16'h0F0F, "R7 untouched ovs", lf_ovscfg, 16'h0F0F);

    compare_on = 0;
    finish_sim();
  end
endmodule